// File: doc/BRIEF.md
# USB Device Charger-Port Classifier

This block sequences charger detection on a USB device port. After a start pulse it walks three phases strictly in order: it drives the contact-detect enable until the D+ single-ended level has been low long enough to prove data contact, then drives the primary-detect enable and reads the charger-detect comparator, and, only when that comparator said "charger", drives the secondary-detect enable and reads the comparator again. The outcome is a two-bit port classification: standard downstream, charging downstream or dedicated charging.

All timings are cycle-count parameters: the contact debounce (10 ms at 50 MHz by default), the contact timeout (900 ms), and the settle time each comparator is given after its phase enable rises (40 ms). A missing contact does not stall the sequence. The block raises a timeout flag and continues with primary detection. The result, the done flag and the timeout flag hold until the next start pulse.

Top module: `chgport_classifier`

## Requirements
- R1: While reset is asserted, and after it is released, all three phase enables, the done flag and the timeout flag are 0 and the port type is 00 (unknown).
- R2: A start pulse in the idle state clears the port type to 00, clears done and timeout, and raises the contact-detect enable in the cycle after the start edge.
- R3: The contact-detect enable stays high until D+ has been sampled low on DBNC_CYC consecutive clock edges. A high sample restarts the count. The phase then ends and primary detection begins.
- R4: If contact is not proven within TMO_CYC cycles of contact detection, the timeout flag is set to 1 and primary detection begins anyway.
- R5: The primary-detect enable is high for exactly SETTLE_CYC cycles, and the comparator is sampled at the last of them. A 0 ends the run with port type 01 (standard downstream) and done set to 1.
- R6: A 1 in primary detection starts secondary detection. Its enable is high for exactly SETTLE_CYC cycles, and the comparator is then sampled. A 0 gives port type 10 (charging downstream) and a 1 gives 11 (dedicated charging). In both cases done is set to 1.
- R7: At most one phase enable is high at any time, and none is high once the run is done.
- R8: After a run, the port type, done and timeout hold until the next start pulse. A start pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a classification run |
| dp_level_i | input | 1 | Single-ended D+ level, already synchronised |
| chg_det_i | input | 1 | Charger-detect comparator output |
| dcd_en_o | output | 1 | Enables contact-detect current source and D- pull-down |
| pri_en_o | output | 1 | Enables primary-detect source and comparator |
| sec_en_o | output | 1 | Enables secondary-detect source and comparator |
| port_type_o | output | 2 | 00 unknown, 01 standard, 10 charging downstream, 11 dedicated charging |
| done_o | output | 1 | Classification finished |
| timeout_o | output | 1 | Contact was not proven within the timeout |

## Verification
The bench counts how many cycles each phase enable stays high for every stimulus. A design with an off-by-one in the debounce, timeout or settle compare therefore shows a wrong phase length, not merely a slow result. D+ is bounced early and in the middle of contact detection. A debouncer that does not restart on a high sample would end the phase several cycles too early. Runs with D+ never low must report the timeout and still classify, and a design that stalls or skips primary detection would miss the port type. A start pulse is injected during primary detection, where a design that restarts would repeat contact detection. The bench also checks that the result survives idle cycles and is cleared by the next start.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_CONTACT   = 2'd1,
        ST_PRIMARY   = 2'd2,
        ST_SECONDARY = 2'd3
    } det_state_e;

    typedef enum logic [1:0] {
        PT_UNKNOWN   = 2'b00,
        PT_STANDARD  = 2'b01,
        PT_CHG_DOWN  = 2'b10,
        PT_DEDICATED = 2'b11
    } port_type_e;

    typedef struct packed {
        det_state_e state;
        port_type_e ptype;
        logic       done;
        logic       tmo;
    } det_regs_t;

endpackage

// File: rtl/chgdet_cycle_cnt.sv
module chgdet_cycle_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != {W{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/chgport_classifier.sv
module chgport_classifier
    import chgdet_pkg::*;
#(
    parameter int DBNC_CYC   = 500000,
    parameter int TMO_CYC    = 45000000,
    parameter int SETTLE_CYC = 2000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       dp_level_i,
    input  logic       chg_det_i,
    output logic       dcd_en_o,
    output logic       pri_en_o,
    output logic       sec_en_o,
    output logic [1:0] port_type_o,
    output logic       done_o,
    output logic       timeout_o
);
    localparam int PH_MAX  = (TMO_CYC > SETTLE_CYC) ? TMO_CYC : SETTLE_CYC;
    localparam int PH_W    = $clog2(PH_MAX + 1);
    localparam int DBNC_W  = $clog2(DBNC_CYC + 1);
    localparam logic [PH_W-1:0]   TMO_LAST    = PH_W'(TMO_CYC - 1);
    localparam logic [PH_W-1:0]   SETTLE_LAST = PH_W'(SETTLE_CYC - 1);
    localparam logic [DBNC_W-1:0] DBNC_LAST   = DBNC_W'(DBNC_CYC - 1);

    det_regs_t r_d, r_q;
    logic [PH_W-1:0]   ph_cnt;
    logic [DBNC_W-1:0] low_cnt;
    logic              ph_clr;
    logic              low_clr;
    logic              contact_seen;
    logic              settled;

    // Phase timer restarts whenever the state changes.
    chgdet_cycle_cnt #(.W(PH_W)) u_phase_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ph_clr),
        .inc_i (1'b1),
        .cnt_o (ph_cnt)
    );

    // Consecutive low samples of D+ during contact detection.
    chgdet_cycle_cnt #(.W(DBNC_W)) u_low_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (low_clr),
        .inc_i (1'b1),
        .cnt_o (low_cnt)
    );

    assign low_clr      = (r_q.state != ST_CONTACT) || dp_level_i;
    assign contact_seen = !dp_level_i && (low_cnt == DBNC_LAST);
    assign settled      = (ph_cnt == SETTLE_LAST);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_CONTACT;
                    r_d.ptype = PT_UNKNOWN;
                    r_d.done  = 1'b0;
                    r_d.tmo   = 1'b0;
                end
            end
            ST_CONTACT: begin
                if (contact_seen) begin
                    r_d.state = ST_PRIMARY;
                end else if (ph_cnt == TMO_LAST) begin
                    r_d.tmo   = 1'b1;
                    r_d.state = ST_PRIMARY;
                end
            end
            ST_PRIMARY: begin
                if (settled) begin
                    if (chg_det_i) begin
                        r_d.state = ST_SECONDARY;
                    end else begin
                        r_d.ptype = PT_STANDARD;
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_SECONDARY: begin
                if (settled) begin
                    r_d.ptype = chg_det_i ? PT_DEDICATED : PT_CHG_DOWN;
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        ph_clr = (r_d.state != r_q.state) || (r_q.state == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, ptype: PT_UNKNOWN, done: 1'b0, tmo: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign dcd_en_o    = (r_q.state == ST_CONTACT);
    assign pri_en_o    = (r_q.state == ST_PRIMARY);
    assign sec_en_o    = (r_q.state == ST_SECONDARY);
    assign port_type_o = r_q.ptype;
    assign done_o      = r_q.done;
    assign timeout_o   = r_q.tmo;
endmodule

// File: rtl/chgport_classifier_chk.sv
module chgport_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       dcd_en_o,
    input logic       pri_en_o,
    input logic       sec_en_o,
    input logic [1:0] port_type_o,
    input logic       done_o,
    input logic       timeout_o
);
    logic busy;
    assign busy = dcd_en_o || pri_en_o || sec_en_o;

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dcd_en_o, pri_en_o, sec_en_o}) <= 1); // R7

    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy); // R7

    AST_DONE_HAS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (port_type_o != 2'b00)); // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> (dcd_en_o && !done_o && !timeout_o && port_type_o == 2'b00)); // R2

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !busy) |=> ($stable(port_type_o) && $stable(done_o) && $stable(timeout_o))); // R8

    AST_TMO_FROM_CONTACT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (pri_en_o && $past(dcd_en_o))); // R4

    AST_CONTACT_TO_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dcd_en_o) |-> pri_en_o); // R3

    AST_SECONDARY_FROM_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_en_o) |-> $past(pri_en_o)); // R6
endmodule

bind chgport_classifier chgport_classifier_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .dcd_en_o    (dcd_en_o),
    .pri_en_o    (pri_en_o),
    .sec_en_o    (sec_en_o),
    .port_type_o (port_type_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o)
);

// File: tb/test_chgport_classifier.sv
`timescale 1ns/1ps
module test_chgport_classifier;
    localparam int DBNC   = 8;
    localparam int TMO    = 40;
    localparam int SETTLE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic dp_level_i = 1'b1;
    logic chg_det_i;
    logic dcd_en_o, pri_en_o, sec_en_o, done_o, timeout_o;
    logic [1:0] port_type_o;
    logic cmp_pri = 1'b0;
    logic cmp_sec = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // Analog model: comparator answer depends on which phase is enabled.
    assign chg_det_i = pri_en_o ? cmp_pri : (sec_en_o ? cmp_sec : 1'b0);

    chgport_classifier #(.DBNC_CYC(DBNC), .TMO_CYC(TMO), .SETTLE_CYC(SETTLE)) i_chgport_classifier (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dp_level_i(dp_level_i),
        .chg_det_i(chg_det_i), .dcd_en_o(dcd_en_o), .pri_en_o(pri_en_o),
        .sec_en_o(sec_en_o), .port_type_o(port_type_o), .done_o(done_o),
        .timeout_o(timeout_o)
    );

    typedef struct packed {
        logic [1:0] mode;   // 0 D+ low, 1 D+ high, 2 high cycles 1..3, 3 high at cycle 7
        logic       pchg;
        logic       schg;
        logic [1:0] ty;
        logic       tmo;
        logic [7:0] nd;
        logic [7:0] np;
        logic [7:0] ns;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 1'b0, 2'b01, 1'b0, 8'd8,  8'd5, 8'd0},
        '{2'd0, 1'b1, 1'b0, 2'b10, 1'b0, 8'd8,  8'd5, 8'd5},
        '{2'd0, 1'b1, 1'b1, 2'b11, 1'b0, 8'd8,  8'd5, 8'd5},
        '{2'd1, 1'b0, 1'b0, 2'b01, 1'b1, 8'd40, 8'd5, 8'd0},
        '{2'd1, 1'b1, 1'b1, 2'b11, 1'b1, 8'd40, 8'd5, 8'd5},
        '{2'd2, 1'b1, 1'b0, 2'b10, 1'b0, 8'd11, 8'd5, 8'd5},
        '{2'd3, 1'b0, 1'b0, 2'b01, 1'b0, 8'd15, 8'd5, 8'd0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic dp_for(input logic [1:0] mode, input int k);
        case (mode)
            2'd0: return 1'b0;
            2'd1: return 1'b1;
            2'd2: return (k <= 3);
            default: return (k == 7);
        endcase
    endfunction

    task automatic run_vec(input vec_t v, input bit poke_start);
        int nd = 0, np = 0, ns = 0, viol = 0, guard = 0;
        bit finished = 0;
        cmp_pri = v.pchg;
        cmp_sec = v.schg;
        @(negedge clk);
        start_i = 1'b1;
        dp_level_i = dp_for(v.mode, 1);
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", "type cleared", port_type_o, 0);
        chk("R2", "done cleared", done_o, 0);
        chk("R2", "timeout cleared", timeout_o, 0);
        chk("R2", "contact enable", dcd_en_o, 1);
        while (!finished && guard < 500) begin
            guard++;
            if ((dcd_en_o + pri_en_o + sec_en_o) > 1) viol++;
            if (dcd_en_o) begin
                nd++;
                dp_level_i = dp_for(v.mode, nd);
            end
            if (pri_en_o) np++;
            if (sec_en_o) ns++;
            start_i = poke_start && pri_en_o && (np == 2);
            @(negedge clk);
            finished = done_o;
        end
        start_i = 1'b0;
        chk("R3", "contact cycles", nd, int'(v.nd));
        chk("R5", "primary cycles", np, int'(v.np));
        chk("R6", "secondary cycles", ns, int'(v.ns));
        chk("R6", "port type", port_type_o, int'(v.ty));
        chk("R4", "timeout flag", timeout_o, int'(v.tmo));
        chk("R7", "enable overlap", viol, 0);
        chk("R7", "enables idle at done", dcd_en_o | pri_en_o | sec_en_o, 0);
        dp_level_i = ~dp_level_i;
        repeat (3) @(negedge clk);
        chk("R8", "type held", port_type_o, int'(v.ty));
        chk("R8", "done held", done_o, 1);
        chk("R8", "timeout held", timeout_o, int'(v.tmo));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "enables in reset", dcd_en_o | pri_en_o | sec_en_o, 0);
        chk("R1", "type in reset", port_type_o, 0);
        chk("R1", "flags in reset", done_o | timeout_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "idle after reset", {dcd_en_o, done_o, port_type_o}, 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], 1'b0);
        end

        // R8: start during primary detection is ignored
        run_vec(VEC[1], 1'b1);

        // R1: reset in the middle of a run
        @(negedge clk);
        start_i = 1'b1;
        dp_level_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "enables after mid-run reset", dcd_en_o | pri_en_o | sec_en_o, 0);
        chk("R1", "result after mid-run reset", {done_o, timeout_o, port_type_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R5: a fresh run after reset still classifies
        run_vec(VEC[0], 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule